// File: doc/BRIEF.md
# Aperture Address Remapper

This block sits in front of one bus master. It splits the 32-bit address space into sixteen equal 256 MB windows. The window is chosen by the top address nibble. Each window carries two 4-bit fields:

- a target select, which names the downstream slave;
- a replacement nibble, which overwrites the top four bits of the outgoing address.

The lower 28 address bits pass through unchanged. A select of zero marks a window with no target. An access to such a window raises a decode-error flag instead of reaching a slave.

Software programs the map through a single-cycle register write port. The writes land in a shadow bank, so the live decode does not change while the map is only partly written. A write of 1 to the update register copies the whole shadow bank into the active bank at once. The decode itself is purely combinational from the active bank.

Top module: `aper_remap`

## Requirements
- R1: Address bits [31:28] pick one of sixteen windows, and only that window's fields steer the outputs.
- R2: `slvIdx` equals the active 4-bit select field of the addressed window.
- R3: `xlatAddr` is the addressed window's active replacement nibble in bits [31:28], joined with address bits [27:0] passed unchanged.
- R4: Select fields are written at byte address 0x0 (windows 0-7) and 0x4 (windows 8-15). Window w occupies bits [4(w mod 8)+3 : 4(w mod 8)] of its register. Address bits [1:0] are ignored.
- R5: Replacement nibbles use the same packing, at byte address 0x8 (windows 0-7) and 0xC (windows 8-15).
- R6: When the addressed window's active select is 0, `decErr` is 1 and `slvIdx` is 0. Otherwise `decErr` is 0.
- R7: A write to a shadow register does not change the decode outputs until an update is committed.
- R8: A write with data bit 0 = 1 to byte address 0x10 copies every shadow field into the active bank. The new map shows at the outputs from the clock edge after the edge that captured the write. Shadow contents are kept after the commit, so later partial rewrites merge with them.
- R9: A write to 0x10 with data bit 0 = 0 does nothing. A write to any unmapped address does nothing.
- R10: After reset, both banks hold zero. Every window then reports `decErr` = 1, `slvIdx` = 0 and a replacement nibble of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfgWrEn | input | 1 | Register write strobe, one cycle per write |
| cfgAddr | input | 8 | Register byte address |
| cfgWrData | input | 32 | Register write data |
| mstAddr | input | 32 | Master address to decode |
| slvIdx | output | 4 | Selected target index (0 = none) |
| xlatAddr | output | 32 | Translated address |
| decErr | output | 1 | Addressed window has no target |

## Verification
The assertions check on every cycle that:
- the active bank holds still unless a commit strobe was present;
- a commit copies exactly the previous shadow contents;
- the shadow bank moves only on a write strobe;
- a commit always traces back to an update write one cycle earlier.

Only the bench scenarios can show the rest:
- that the register packing places each field in the right window;
- that the translated address and the error flag match the programmed map across the windows;
- that ignored writes leave the map intact;
- the exact cycle in which a commit becomes visible.

// File: rtl/aper_remap_pkg.sv
`timescale 1ns/1ps
package aper_remap_pkg;
  localparam int ADDR_W         = 32;
  localparam int WIN_BITS       = 4;
  localparam int NUM_WIN        = 1 << WIN_BITS;
  localparam int FIELD_W        = 4;
  localparam int DATA_W         = 32;
  localparam int FIELDS_PER_REG = DATA_W / FIELD_W;
  localparam int REGS_PER_BANK  = NUM_WIN / FIELDS_PER_REG;
  localparam int CFG_ADDR_W     = 8;
  localparam int WORD_LSB       = 2;
  localparam int WIDX_W         = CFG_ADDR_W - WORD_LSB;
  localparam int UPDATE_WORD    = 2 * REGS_PER_BANK;
  localparam int MAP_W          = NUM_WIN * FIELD_W;

  // Strobes from control to datapath
  typedef struct packed {
    logic [REGS_PER_BANK-1:0] selWr;
    logic [REGS_PER_BANK-1:0] offWr;
    logic                     commit;
  } mapStrobe_t;
endpackage

// File: rtl/aper_remap_ctrl.sv
`timescale 1ns/1ps
module aper_remap_ctrl
  import aper_remap_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfgWrEn,
  input  logic [CFG_ADDR_W-1:0] cfgAddr,
  input  logic [DATA_W-1:0]     cfgWrData,
  output mapStrobe_t            strb
);
  logic [WIDX_W-1:0] wordIdx;
  logic              commitReq;
  logic              commitQ;

  assign wordIdx   = cfgAddr[CFG_ADDR_W-1:WORD_LSB];
  assign commitReq = cfgWrEn && (wordIdx == WIDX_W'(UPDATE_WORD)) && cfgWrData[0];

  always_comb begin
    strb = '0;
    for (int r = 0; r < REGS_PER_BANK; r++) begin
      strb.selWr[r] = cfgWrEn && (wordIdx == WIDX_W'(r));
      strb.offWr[r] = cfgWrEn && (wordIdx == WIDX_W'(r + REGS_PER_BANK));
    end
    strb.commit = commitQ;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) commitQ <= 1'b0;
    else        commitQ <= commitReq;
  end

  // R4
  write_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strb.selWr, strb.offWr}));

  // R8
  commit_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strb.commit) |-> $past(cfgWrEn) && $past(cfgWrData[0]));
endmodule

// File: rtl/aper_remap_dpath.sv
`timescale 1ns/1ps
module aper_remap_dpath
  import aper_remap_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  mapStrobe_t         strb,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [ADDR_W-1:0]  mstAddr,
  output logic [FIELD_W-1:0] slvIdx,
  output logic [ADDR_W-1:0]  xlatAddr,
  output logic               decErr
);
  logic [MAP_W-1:0]    shSelV, shOffV, actSelV, actOffV;
  logic [WIN_BITS-1:0] winIdx;
  logic [FIELD_W-1:0]  selField, offField;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shSelV  <= '0;
      shOffV  <= '0;
      actSelV <= '0;
      actOffV <= '0;
    end else begin
      for (int w = 0; w < NUM_WIN; w++) begin
        if (strb.selWr[w / FIELDS_PER_REG])
          shSelV[w*FIELD_W +: FIELD_W] <= wrData[(w % FIELDS_PER_REG)*FIELD_W +: FIELD_W];
        if (strb.offWr[w / FIELDS_PER_REG])
          shOffV[w*FIELD_W +: FIELD_W] <= wrData[(w % FIELDS_PER_REG)*FIELD_W +: FIELD_W];
      end
      if (strb.commit) begin
        actSelV <= shSelV;
        actOffV <= shOffV;
      end
    end
  end

  assign winIdx   = mstAddr[ADDR_W-1 -: WIN_BITS];
  assign selField = actSelV[winIdx*FIELD_W +: FIELD_W];
  assign offField = actOffV[winIdx*FIELD_W +: FIELD_W];

  always_comb begin
    decErr   = (selField == '0);
    slvIdx   = decErr ? '0 : selField;
    xlatAddr = {offField, mstAddr[ADDR_W-WIN_BITS-1:0]};
  end

  // R7
  active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.commit |=> $stable(actSelV) && $stable(actOffV));

  // R8
  commit_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.commit |=> (actSelV == $past(shSelV)) && (actOffV == $past(shOffV)));

  // R4
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|strb.selWr) |=> $stable(shSelV));

  // R5
  offset_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|strb.offWr) |=> $stable(shOffV));
endmodule

// File: rtl/aper_remap.sv
`timescale 1ns/1ps
module aper_remap
  import aper_remap_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfgWrEn,
  input  logic [CFG_ADDR_W-1:0] cfgAddr,
  input  logic [DATA_W-1:0]     cfgWrData,
  input  logic [ADDR_W-1:0]     mstAddr,
  output logic [FIELD_W-1:0]    slvIdx,
  output logic [ADDR_W-1:0]     xlatAddr,
  output logic                  decErr
);
  mapStrobe_t strb;

  aper_remap_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .strb(strb)
  );

  aper_remap_dpath dpath_i (
    .clk(clk), .rst_n(rst_n), .strb(strb), .wrData(cfgWrData),
    .mstAddr(mstAddr), .slvIdx(slvIdx), .xlatAddr(xlatAddr), .decErr(decErr)
  );
endmodule

// File: tb/aper_remap_tb_top.sv
`timescale 1ns/1ps
module aper_remap_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [7:0]  cfgAddr = '0;
  logic [31:0] cfgWrData = '0;
  logic [31:0] mstAddr = '0;
  logic [3:0]  slvIdx;
  logic [31:0] xlatAddr;
  logic        decErr;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  aper_remap dut_i (
    .clk(clk), .rst_n(rst_n), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .mstAddr(mstAddr), .slvIdx(slvIdx),
    .xlatAddr(xlatAddr), .decErr(decErr)
  );

  // Map used by the table: select and replacement words
  localparam logic [31:0] SEL_LO = 32'h0000_0233;
  localparam logic [31:0] SEL_HI = 32'h6330_1111;
  localparam logic [31:0] OFF_LO = 32'h0000_0010;
  localparam logic [31:0] OFF_HI = 32'h0ED0_3210;

  // {address, expected slave, expected translated address, expected error}
  localparam logic [68:0] VEC [10] = '{
    {32'h0123_4567, 4'd3, 32'h0123_4567, 1'b0},
    {32'h1ABC_DEF0, 4'd3, 32'h1ABC_DEF0, 1'b0},
    {32'h2000_0004, 4'd2, 32'h0000_0004, 1'b0},
    {32'h5555_5555, 4'd0, 32'h0555_5555, 1'b1},
    {32'h8765_4321, 4'd1, 32'h0765_4321, 1'b0},
    {32'hB000_0FFF, 4'd1, 32'h3000_0FFF, 1'b0},
    {32'hC123_0000, 4'd0, 32'h0123_0000, 1'b1},
    {32'hD0F0_0F0F, 4'd3, 32'hD0F0_0F0F, 1'b0},
    {32'hEFFF_FFFF, 4'd3, 32'hEFFF_FFFF, 1'b0},
    {32'hF000_0001, 4'd6, 32'h0000_0001, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgAddr = a; cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0; cfgAddr = '0; cfgWrData = '0;
  endtask

  task automatic probe(input string req, input logic [31:0] a, input logic [3:0] s,
                       input logic [31:0] x, input logic e);
    mstAddr = a;
    #1;
    chk(req, {28'd0, slvIdx}, {28'd0, s});
    chk(req, xlatAddr, x);
    chk(req, {31'd0, decErr}, {31'd0, e});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state: every window empty
    probe("R10", 32'h0000_0000, 4'd0, 32'h0000_0000, 1'b1);
    probe("R10", 32'h9ABC_1234, 4'd0, 32'h0ABC_1234, 1'b1);
    probe("R10", 32'hFFFF_FFFF, 4'd0, 32'h0FFF_FFFF, 1'b1);

    // R7 shadow writes are invisible before commit
    cfgWrite(8'h00, SEL_LO);
    cfgWrite(8'h04, SEL_HI);
    cfgWrite(8'h08, OFF_LO);
    cfgWrite(8'h0C, OFF_HI);
    probe("R7", 32'hF000_0001, 4'd0, 32'h0000_0001, 1'b1);

    // R9 update with bit 0 clear, and an unmapped write, do nothing
    cfgWrite(8'h10, 32'hFFFF_FFFE);
    cfgWrite(8'h14, 32'hFFFF_FFFF);
    cfgWrite(8'h20, 32'hFFFF_FFFF);
    repeat (2) @(negedge clk);
    probe("R9", 32'h0123_4567, 4'd0, 32'h0123_4567, 1'b1);

    // R8 commit timing: old map right after the write edge, new map one edge later
    cfgWrite(8'h10, 32'h0000_0001);
    probe("R8", 32'h0123_4567, 4'd0, 32'h0123_4567, 1'b1);
    @(negedge clk);
    probe("R8", 32'h0123_4567, 4'd3, 32'h0123_4567, 1'b0);

    // R1 R2 R3 R4 R5 R6 table walk
    foreach (VEC[i]) begin
      probe("R1/R2/R3/R4/R5/R6", VEC[i][68:37], VEC[i][36:33], VEC[i][32:1], VEC[i][0]);
    end

    // R8 partial rewrite merges with retained shadow: clear window 15 only
    cfgWrite(8'h04, 32'h0330_1111);
    cfgWrite(8'h10, 32'h0000_0001);
    @(negedge clk);
    // R6 window 15 now has no target
    probe("R6", 32'hF000_0001, 4'd0, 32'h0000_0001, 1'b1);
    probe("R8", 32'hB000_0FFF, 4'd1, 32'h3000_0FFF, 1'b0);
    probe("R8", 32'h2000_0004, 4'd2, 32'h0000_0004, 1'b0);

    // R4 misaligned byte address maps to the same word (bits [1:0] ignored)
    cfgWrite(8'h03, 32'h0000_0005);
    cfgWrite(8'h10, 32'h0000_0001);
    @(negedge clk);
    probe("R4", 32'h0000_0010, 4'd5, 32'h0000_0010, 1'b0);
    probe("R4", 32'h2000_0010, 4'd0, 32'h0000_0010, 1'b1);

    // R10 reset mid-run clears the map again
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    probe("R10", 32'hB000_0FFF, 4'd0, 32'h0000_0FFF, 1'b1);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule